// File: doc/BRIEF.md
# Sleep Interval Timer with Watchdog

This block counts ticks from a slow oscillator and raises a periodic wake-up interrupt. A 15-bit counter runs freely and never clears except on reset. A 2-bit period code picks how many of its low-order bits must wrap together for a boundary: 6, 9, 12 or 15 bits. That gives periods of 64, 512, 4096 or 32768 ticks. At a 32.768 kHz tick these are roughly 2 ms, 16 ms, 125 ms and 1 s.

A watchdog counts interval boundaries. If three boundaries go by with no kick, it raises a reset request. The request stays high until the next synchronous reset. Software kicks the watchdog once per boundary, or more often. A kick clears only the boundary count and leaves the interval phase alone, so kicks never shift when the interrupt fires.

The block moves no data, so there is no valid/ready handshake. Every pin is a plain level or strobe, sampled on the rising clock edge. The period code is a live input, and code 00 (64 ticks) is the value software should hold after reset.

Top module: `nap_timer`

## Requirements
- R1: While `srst` is high, and in the cycle after it drops, `sleep_irq` and `wd_bite` are low. The counter restarts from zero, so with code 00 the first interrupt follows the 64th tick after reset.
- R2: With `period_sel` = 00, `sleep_irq` pulses once every 64 ticks.
- R3: Codes 01, 10 and 11 give one `sleep_irq` pulse every 512, 4096 and 32768 ticks respectively.
- R4: `sleep_irq` is high for exactly one cycle. That cycle directly follows the clock edge at which the rollover tick was sampled.
- R5: A cycle with `tick_en` low does not advance the counter, and it never produces an interrupt.
- R6: Changing `period_sel` does not reset the counter. The next interrupt comes when the count next reaches a multiple of the new period.
- R7: With `wd_enable` high, `wd_bite` rises in the same cycle as the third `sleep_irq` pulse after reset, a kick, or enabling.
- R8: `wd_kick` clears the watchdog's boundary count only. Interrupt timing is unchanged, and kicks spaced less than three periods apart keep `wd_bite` low.
- R9: Once high, `wd_bite` stays high until `srst`, even if `wd_enable` then drops.
- R10: While `wd_enable` is low, `wd_bite` cannot rise and the boundary count is held at zero.
- R11: A kick in the same cycle as a boundary wins. That boundary is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle enable per slow oscillator tick |
| period_sel | input | 2 | Interval code: 00=64, 01=512, 10=4096, 11=32768 ticks |
| wd_enable | input | 1 | Watchdog enable level |
| wd_kick | input | 1 | Watchdog clear strobe |
| sleep_irq | output | 1 | One-cycle interval interrupt |
| wd_bite | output | 1 | Sticky watchdog reset request |

## Verification
A corrupted interval counter shows up as a shifted interrupt. The error is visible at the very next boundary: within 64 ticks for code 00, and by the end of the longest period at worst. A wrong boundary count in the watchdog only appears when `wd_bite` rises one boundary early or late. A kick that wrongly touches the interval phase shows as a displaced `sleep_irq` on the following boundary. The bench therefore compares both outputs every cycle against an independent model across all four codes, mid-count code changes and kicks timed on boundaries.

// File: rtl/nap_pkg.sv
package nap_pkg;
  // number of selectable interval codes for a 2-bit selector
  localparam int unsigned NAP_SEL_W = 2;
  localparam int unsigned NAP_CODES = 1 << NAP_SEL_W;

  typedef enum logic [NAP_SEL_W-1:0] {
    SPAN_64  = 2'd0,
    SPAN_512 = 2'd1,
    SPAN_4K  = 2'd2,
    SPAN_32K = 2'd3
  } nap_span_e;

  // number of low counter bits that must wrap for interval code 'code'
  function automatic int unsigned nap_span_bits(input int unsigned base,
                                                input int unsigned step,
                                                input int unsigned code);
    return base + step * code;
  endfunction
endpackage

// File: rtl/nap_counter.sv
module nap_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst)         cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R5: no tick, no movement
  assert_hold_R5: assert property (@(posedge clk) disable iff (srst)
    !tick_en |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/nap_boundary.sv
module nap_boundary
  import nap_pkg::*;
#(
  parameter int unsigned CNT_W     = 15,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             boundary,
  output logic             irq
);
  localparam int unsigned NCODES = 1 << SEL_W;

  logic [NCODES-1:0] wrap;

  // one wrap detector per interval code
  for (genvar k = 0; k < NCODES; k++) begin : g_span
    localparam int unsigned BITS = nap_span_bits(BASE_LOG2, STEP_LOG2, k);
    assign wrap[k] = &cnt[BITS-1:0];
  end

  assign boundary = tick_en & wrap[sel];

  logic irq_q;
  always_ff @(posedge clk) begin
    if (srst) irq_q <= 1'b0;
    else      irq_q <= boundary;
  end
  assign irq = irq_q;

  // R4: interrupt is a single-cycle pulse
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (srst)
    irq_q |=> !irq_q);
endmodule

// File: rtl/nap_watchdog.sv
module nap_watchdog #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic srst,
  input  logic boundary,
  input  logic enable,
  input  logic kick,
  output logic bite
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] seen_q;
  logic          bite_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      seen_q <= '0;
      bite_q <= 1'b0;
    end else if (!enable || kick) begin
      seen_q <= '0;
    end else if (boundary) begin
      if (seen_q == LAST) bite_q <= 1'b1;
      else                seen_q <= seen_q + 1'b1;
    end
  end

  assign bite = bite_q;

  // R9: request is sticky
  assert_sticky_R9: assert property (@(posedge clk) disable iff (srst)
    bite_q |=> bite_q);
  // R10: cannot rise while disabled
  assert_gated_R10: assert property (@(posedge clk) disable iff (srst)
    !enable |=> (bite_q == $past(bite_q)));
  // R8: a kick clears the boundary count
  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (srst)
    kick |=> (seen_q == '0));
endmodule

// File: rtl/nap_timer.sv
module nap_timer
  import nap_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned STEP_LOG2 = 3,
  parameter int unsigned WD_LIMIT  = 3
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 tick_en,
  input  logic [NAP_SEL_W-1:0] period_sel,
  input  logic                 wd_enable,
  input  logic                 wd_kick,
  output logic                 sleep_irq,
  output logic                 wd_bite
);
  localparam int unsigned CNT_W = BASE_LOG2 + STEP_LOG2 * (NAP_CODES - 1);

  logic [CNT_W-1:0] cnt;
  logic             boundary;

  nap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .srst(srst), .tick_en(tick_en), .cnt(cnt)
  );

  nap_boundary #(
    .CNT_W(CNT_W), .SEL_W(NAP_SEL_W),
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_bnd (
    .clk(clk), .srst(srst), .tick_en(tick_en), .cnt(cnt),
    .sel(period_sel), .boundary(boundary), .irq(sleep_irq)
  );

  nap_watchdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .srst(srst), .boundary(boundary),
    .enable(wd_enable), .kick(wd_kick), .bite(wd_bite)
  );

  // R7: the request only rises together with an interval interrupt
  assert_bite_on_irq_R7: assert property (@(posedge clk) disable iff (srst)
    $rose(wd_bite) |-> sleep_irq);
  // R5: no interrupt without a tick on the previous edge
  assert_irq_needs_tick_R5: assert property (@(posedge clk) disable iff (srst)
    !tick_en |=> !sleep_irq);
endmodule

// File: tb/sim_nap_timer.sv
module sim_nap_timer;
  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       tick_en = 1'b0;
  logic [1:0] period_sel = 2'b00;
  logic       wd_enable = 1'b0;
  logic       wd_kick = 1'b0;
  logic       sleep_irq;
  logic       wd_bite;

  always #4 clk = ~clk;

  nap_timer u0 (
    .clk(clk), .srst(srst), .tick_en(tick_en), .period_sel(period_sel),
    .wd_enable(wd_enable), .wd_kick(wd_kick),
    .sleep_irq(sleep_irq), .wd_bite(wd_bite)
  );

  typedef struct {
    logic  irq;
    logic  bite;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference model state
  int   m_cnt = 0;
  int   m_seen = 0;
  logic m_bite = 1'b0;

  function automatic int span(input logic [1:0] s);
    case (s)
      2'd0:    return 64;
      2'd1:    return 512;
      2'd2:    return 4096;
      default: return 32768;
    endcase
  endfunction

  // driver: set inputs for the next edge and predict the outputs after it
  task automatic step(input bit t, input logic [1:0] s, input bit e,
                      input bit k, input bit r, input string tag);
    exp_t it;
    bit   bnd;
    @(negedge clk);
    tick_en = t; period_sel = s; wd_enable = e; wd_kick = k; srst = r;
    if (r) begin
      m_cnt = 0; m_seen = 0; m_bite = 1'b0; bnd = 0;
    end else begin
      bnd = t && (((m_cnt + 1) % span(s)) == 0);
      if (t) m_cnt = (m_cnt + 1) % 32768;
      if (!e || k) m_seen = 0;
      else if (bnd) begin
        if (m_seen == 2) m_bite = 1'b1;
        else m_seen++;
      end
    end
    it.irq = bnd; it.bite = m_bite; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run(input int n, input int mode, input logic [1:0] s,
                     input bit e, input string tag);
    for (int i = 0; i < n; i++)
      step((mode == 1) || (mode == 2 && i[0]), s, e, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare design outputs with queued predictions
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (sleep_irq !== it.irq || wd_bite !== it.bite) begin
          errors++;
          $display("FAIL %s: irq=%b bite=%b expected irq=%b bite=%b at %0t",
                   it.tag, sleep_irq, wd_bite, it.irq, it.bite, $time);
        end
      end
    end
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step(1, 2'd0, 0, 0, 1, "R1");
    step(0, 2'd0, 0, 0, 0, "R1");
    // R2, R4: code 00, tick every cycle
    run(200, 1, 2'd0, 0, "R2_R4");
    // R5: sparse and absent ticks
    run(150, 2, 2'd0, 0, "R5");
    run(100, 0, 2'd0, 0, "R5");
    // R8: frequent kicks keep the watchdog quiet, interval phase unchanged
    for (int i = 0; i < 400; i++)
      step(1, 2'd0, 1, (i % 100) == 0, 0, "R8");
    // R7: stop kicking, request on third boundary
    run(250, 1, 2'd0, 1, "R7");
    // R9: sticky, also after disabling
    run(150, 1, 2'd0, 1, "R9");
    run(150, 1, 2'd0, 0, "R9");
    // R3: longer codes
    step(0, 2'd1, 0, 0, 1, "R1");
    run(1200, 1, 2'd1, 0, "R3");
    // R6: switch code mid-count without clearing the counter
    run(200, 1, 2'd0, 0, "R6");
    run(9000, 1, 2'd2, 0, "R3");
    run(70000, 1, 2'd3, 0, "R3");
    // R11: kick placed on each boundary
    step(0, 2'd0, 1, 0, 1, "R1");
    for (int i = 0; i < 400; i++)
      step(1, 2'd0, 1, ((m_cnt + 1) % 64) == 0, 0, "R11");
    // R10: disabled watchdog never bites
    run(400, 1, 2'd0, 0, "R10");
    // R7: enabling starts a fresh count
    run(260, 1, 2'd0, 1, "R7");
    run(4, 0, 2'd0, 1, "R9");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule